// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command pins of a two-bank single-data-rate SDRAM from the device side. On every rising clock edge it decodes the command and updates a model of each bank: idle or active, and the row that is open. It also tracks the burst in flight: its bank, its column, whether it carries auto precharge, and a countdown of its remaining beats. When a command breaks a bank-state rule, the block emits a one-cycle violation pulse with a reason code. A command that breaks a rule is dropped and leaves the model untouched.

The block also turns the DQM pin into two masks. The write mask applies in the same cycle. The read mask applies two clocks later, as the Hi-Z control for read data. The block carries no data stream, so no port uses valid/ready. All pins are plain control and status signals. Every output is registered except the write mask.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With cs_n high the command is deselect. With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 111 no-op. A command is acted on only if cke was high at the previous rising edge. Otherwise it is ignored and raises no violation.
- R2: For a command sampled at edge k, viol and viol_code are updated at edge k and hold for exactly one cycle. viol_code is 0 when there is no violation. A violating command changes no bank or burst state. An auto-precharge close that falls due on the same edge still takes place.
- R3: A mode set while either bank is active raises code 1. A mode set with both banks idle is accepted.
- R4: For the two edges after an accepted mode set, any command other than no-op or deselect raises code 3 and is dropped.
- R5: A refresh while either bank is active raises code 2. This covers self-refresh entry, which is the refresh opcode with cke going from high to low.
- R6: An activate opens the bank selected by ba (0 = bank A, 1 = bank B) and stores addr as its open row. An activate to a bank that is already active raises code 4.
- R7: A read or write to an idle bank raises code 5.
- R8: An accepted read or write starts a burst on bank ba at column addr[7:0]. burst_busy is high for BURST_LEN-1 cycles after the acceptance edge. A new read or write without auto precharge in flight replaces the current burst.
- R9: addr[10] high on a read or write requests auto precharge. While such a burst is busy, any read or write to either bank raises code 6. When its countdown reaches zero the burst's bank closes.
- R10: A burst stop ends a busy burst at once. If that burst had auto precharge, its bank closes on the same edge.
- R11: A precharge with addr[10] high closes both banks and ignores ba. With addr[10] low it closes bank ba. A precharge that hits the bank of a busy burst also ends that burst.
- R12: wr_mask equals dqm in the same cycle. rd_mask equals the dqm value sampled two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | ADDR_W | Address; bit 10 is the auto-precharge / all-banks flag |
| dqm | input | 1 | Data mask |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Violation reason, 0 when none |
| bank_active | output | 2 | Per-bank active flag, bit 0 = bank A |
| open_row_a | output | ROW_W | Row last opened in bank A |
| open_row_b | output | ROW_W | Row last opened in bank B |
| burst_busy | output | 1 | Burst countdown running |
| burst_ap | output | 1 | Running burst carries auto precharge |
| burst_bank | output | 1 | Bank of the latest burst |
| burst_col | output | COL_W | Column of the latest burst |
| wr_mask | output | 1 | Write data mask, zero latency |
| rd_mask | output | 1 | Read data Hi-Z, two-clock latency |

## Verification
A wrong bank flag shows up in two ways. bank_active differs from the expected value right after the edge that should have changed it. Later, a read, write or activate to that bank gets the wrong code. A burst countdown that is off by one gives the wrong code for a read issued at the last beat of an auto-precharge burst. It also shows as a one-cycle shift in the bank closing. A lockout of the wrong length shows as a missing or extra code 3 within three cycles of a mode set. A wrong DQM pipe depth shifts rd_mask by a cycle and is caught within two clocks.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NBANK = 2;

  typedef enum logic [3:0] {
    C_NOP, C_DESEL, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_BST, C_PRE
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE     = 4'd0,
    V_MRS_BUSY = 4'd1,
    V_REF_BUSY = 4'd2,
    V_LOCKOUT  = 4'd3,
    V_ACT_OPEN = 4'd4,
    V_RW_IDLE  = 4'd5,
    V_RW_AP    = 4'd6
  } viol_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
    end else if (open_en) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (close_en) begin
      active <= 1'b0;
    end
  end

  AST_OPEN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !active); // R6
  AST_CLOSE_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && !open_en) |=> (!active && $stable(row))); // R11
endmodule

// File: rtl/sdc_burst.sv
module sdc_burst #(
  parameter int BURST_LEN = 4,
  parameter int COL_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_ap,
  input  logic             start_bank,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic             busy,
  output logic             ap,
  output logic             bank,
  output logic [COL_W-1:0] col,
  output logic             close_req,
  output logic             close_bank
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             ap_q;

  assign busy = (cnt != '0);
  assign ap   = ap_q && busy;

  always_comb begin
    if (start) begin
      close_req  = (BURST_LEN == 1) && start_ap;
      close_bank = start_bank;
    end else begin
      close_req  = ap && (stop || cnt == CNT_W'(1));
      close_bank = bank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ap_q <= 1'b0;
      bank <= 1'b0;
      col  <= '0;
    end else if (start) begin
      cnt  <= LAST;
      ap_q <= start_ap;
      bank <= start_bank;
      col  <= start_col;
    end else if (stop) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !busy); // R10
endmodule

// File: rtl/sdc_dqm.sv
module sdc_dqm (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic wr_mask,
  output logic rd_mask
);
  logic       d1;
  logic [1:0] seen;

  assign wr_mask = dqm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1      <= 1'b0;
      rd_mask <= 1'b0;
      seen    <= '0;
    end else begin
      d1      <= dqm;
      rd_mask <= d1;
      if (seen != 2'd2) seen <= seen + 2'd1;
    end
  end

  AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2) |-> (rd_mask == $past(dqm, 2))); // R12
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  output logic              viol,
  output logic [3:0]        viol_code,
  output logic [NBANK-1:0]  bank_active,
  output logic [ROW_W-1:0]  open_row_a,
  output logic [ROW_W-1:0]  open_row_b,
  output logic              burst_busy,
  output logic              burst_ap,
  output logic              burst_bank,
  output logic [COL_W-1:0]  burst_col,
  output logic              wr_mask,
  output logic              rd_mask
);
  cmd_e       cmd;
  viol_e      code;
  logic       cke_q, live, real_cmd, ok;
  logic [1:0] lock_cnt;
  logic       mrs_ok, act_ok, rw_ok, bst_ok, pre_ok;
  logic       stop, close_req, close_bank;
  logic [ROW_W-1:0] rows [NBANK];

  sdc_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign live     = cke_q;
  assign real_cmd = live && (cmd != C_NOP) && (cmd != C_DESEL);

  always_comb begin
    code = V_NONE;
    if (real_cmd) begin
      if (lock_cnt != 2'd0) code = V_LOCKOUT;
      else begin
        case (cmd)
          C_MRS: if (|bank_active) code = V_MRS_BUSY;
          C_REF: if (|bank_active) code = V_REF_BUSY;
          C_ACT: if (bank_active[ba]) code = V_ACT_OPEN;
          C_RD, C_WR: begin
            if (burst_ap)              code = V_RW_AP;
            else if (!bank_active[ba]) code = V_RW_IDLE;
          end
          default: code = V_NONE;
        endcase
      end
    end
  end

  assign ok     = real_cmd && (code == V_NONE);
  assign mrs_ok = ok && (cmd == C_MRS);
  assign act_ok = ok && (cmd == C_ACT);
  assign rw_ok  = ok && (cmd == C_RD || cmd == C_WR);
  assign bst_ok = ok && (cmd == C_BST);
  assign pre_ok = ok && (cmd == C_PRE);
  assign stop   = burst_busy &&
                  (bst_ok || (pre_ok && (addr[AP_BIT] || ba == burst_bank)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      lock_cnt  <= '0;
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      cke_q     <= cke;
      viol      <= (code != V_NONE);
      viol_code <= code;
      if (mrs_ok)                lock_cnt <= 2'd2;
      else if (lock_cnt != 2'd0) lock_cnt <= lock_cnt - 2'd1;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic open_en, close_en;
    assign open_en  = act_ok && (ba == 1'(b));
    assign close_en = (pre_ok && (addr[AP_BIT] || ba == 1'(b))) ||
                      (close_req && close_bank == 1'(b));
    sdc_bank #(.ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .open_en(open_en), .close_en(close_en),
      .row_in(addr[ROW_W-1:0]), .active(bank_active[b]), .row(rows[b])
    );
  end

  assign open_row_a = rows[0];
  assign open_row_b = rows[1];

  sdc_burst #(.BURST_LEN(BURST_LEN), .COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(rw_ok), .start_ap(addr[AP_BIT]),
    .start_bank(ba), .start_col(addr[COL_W-1:0]), .stop(stop),
    .busy(burst_busy), .ap(burst_ap), .bank(burst_bank), .col(burst_col),
    .close_req(close_req), .close_bank(close_bank)
  );

  sdc_dqm u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm), .wr_mask(wr_mask), .rd_mask(rd_mask)
  );

  AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd == C_MRS && lock_cnt == 2'd0 && |bank_active)
      |=> (viol && viol_code == V_MRS_BUSY)); // R3
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (real_cmd && lock_cnt != 2'd0) |=> (viol_code == V_LOCKOUT)); // R4
  AST_VIOL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (code != V_NONE && !close_req) |=> $stable(bank_active)); // R2
  AST_AP_BLOCKS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_ap && live && (cmd == C_RD || cmd == C_WR)) |=> viol); // R9
  AST_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 4'd0)); // R2
endmodule

// File: tb/tb_sdram_cmd_checker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_checker;
  localparam int BL = 4;
  localparam bit [2:0] OP_MRS = 3'b000, OP_REF = 3'b001, OP_ACT = 3'b011,
                       OP_RD = 3'b101, OP_WR = 3'b100, OP_BST = 3'b110,
                       OP_PRE = 3'b010, OP_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic ba = 1'b0, dqm = 1'b0;
  logic [10:0] addr = '0;
  logic viol, burst_busy, burst_ap, burst_bank, wr_mask, rd_mask;
  logic [3:0] viol_code;
  logic [1:0] bank_active;
  logic [10:0] open_row_a, open_row_b;
  logic [7:0] burst_col;

  sdram_cmd_checker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
    .viol(viol), .viol_code(viol_code), .bank_active(bank_active),
    .open_row_a(open_row_a), .open_row_b(open_row_b),
    .burst_busy(burst_busy), .burst_ap(burst_ap), .burst_bank(burst_bank),
    .burst_col(burst_col), .wr_mask(wr_mask), .rd_mask(rd_mask)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  string sec = "R2";
  // reference model state
  int m_act[2], m_row[2], m_cnt, m_ap, m_bank, m_col, m_lock, m_ckep, m_d1, m_d2;
  int e_code;

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL [%s] %s: got %0d expected %0d (cycle %0d)", sec, tag, got, exp, cyc);
    end
  endtask

  function automatic string code_tag(int c);
    case (c)
      1: return "R3 code";
      2: return "R5 code";
      3: return "R4 code";
      4: return "R6 code";
      5: return "R7 code";
      6: return "R9 code";
      default: return "R2 code";
    endcase
  endfunction

  task automatic compare();
    chk("R2 viol", int'(viol), int'(e_code != 0));
    chk(code_tag(e_code), int'(viol_code), e_code);
    chk("R6 bank A", int'(bank_active[0]), m_act[0]);
    chk("R6 bank B", int'(bank_active[1]), m_act[1]);
    chk("R6 row A", int'(open_row_a), m_row[0]);
    chk("R6 row B", int'(open_row_b), m_row[1]);
    chk("R8 busy", int'(burst_busy), int'(m_cnt > 0));
    chk("R9 ap", int'(burst_ap), int'(m_cnt > 0 && m_ap != 0));
    chk("R8 bank", int'(burst_bank), m_bank);
    chk("R8 col", int'(burst_col), m_col);
    chk("R12 rd_mask", int'(rd_mask), m_d2);
  endtask

  task automatic step(bit cke_i, bit cs_i, bit [2:0] op, bit ba_i, int a);
    int c, live, nop, ok, ncnt;
    int cl[2];
    bit dq;
    @(negedge clk);
    cyc++;
    dq = ((cyc * 7) % 5) < 2;
    cke = cke_i; cs_n = cs_i; {ras_n, cas_n, we_n} = op; ba = ba_i;
    addr = 11'(a); dqm = dq;
    #1 chk("R12 wr_mask", int'(wr_mask), int'(dq));
    live = m_ckep; nop = (cs_i || op == OP_NOP) ? 1 : 0;
    c = 0;
    if (live != 0 && nop == 0) begin
      if (m_lock > 0) c = 3;
      else if (op == OP_MRS && (m_act[0] | m_act[1]) != 0) c = 1;
      else if (op == OP_REF && (m_act[0] | m_act[1]) != 0) c = 2;
      else if (op == OP_ACT && m_act[ba_i] != 0) c = 4;
      else if (op == OP_RD || op == OP_WR) begin
        if (m_cnt > 0 && m_ap != 0) c = 6;
        else if (m_act[ba_i] == 0) c = 5;
      end
    end
    ok = (live != 0 && nop == 0 && c == 0) ? 1 : 0;
    cl[0] = 0; cl[1] = 0;
    ncnt = m_cnt;
    if (ok != 0 && (op == OP_RD || op == OP_WR)) begin
      ncnt = BL - 1; m_ap = (a >> 10) & 1; m_bank = ba_i; m_col = a & 255;
      if (BL == 1 && m_ap != 0) cl[ba_i] = 1;
    end else if (m_cnt > 0 && ok != 0 && (op == OP_BST ||
               (op == OP_PRE && (((a >> 10) & 1) != 0 || ba_i == m_bank)))) begin
      if (m_ap != 0) cl[m_bank] = 1;
      ncnt = 0;
    end else if (m_cnt > 0) begin
      if (m_cnt == 1 && m_ap != 0) cl[m_bank] = 1;
      ncnt = m_cnt - 1;
    end
    if (ok != 0 && op == OP_PRE) begin
      if (((a >> 10) & 1) != 0) begin cl[0] = 1; cl[1] = 1; end
      else cl[ba_i] = 1;
    end
    if (ok != 0 && op == OP_ACT) begin m_act[ba_i] = 1; m_row[ba_i] = a & 2047; end
    for (int b = 0; b < 2; b++) if (cl[b] != 0) m_act[b] = 0;
    if (ok != 0 && op == OP_MRS) m_lock = 2; else if (m_lock > 0) m_lock--;
    m_cnt = ncnt; m_ckep = cke_i; m_d2 = m_d1; m_d1 = int'(dq); e_code = c;
    @(posedge clk);
    #1 compare();
  endtask

  task automatic cmd(bit [2:0] op, bit b, int a);
    step(1'b1, 1'b0, op, b, a);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, OP_NOP, 1'b0, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_act[0] = 0; m_act[1] = 0; m_row[0] = 0; m_row[1] = 0;
    m_cnt = 0; m_ap = 0; m_bank = 0; m_col = 0; m_lock = 0; m_ckep = 1;
    m_d1 = 0; m_d2 = 0; e_code = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    sec = "R2"; compare();                       // reset state
    sec = "R3"; cmd(OP_MRS, 0, 11'h033);         // legal, banks idle
    sec = "R4"; cmd(OP_ACT, 0, 11'h155);         // locked out
    idle(1);
    cmd(OP_ACT, 0, 11'h155);                     // accepted
    sec = "R3"; cmd(OP_MRS, 0, 0);               // bank A open
    sec = "R5"; cmd(OP_REF, 0, 0);
    step(1'b0, 1'b0, OP_REF, 1'b0, 0);           // self refresh entry, bank open
    sec = "R1"; step(1'b0, 1'b0, OP_MRS, 1'b0, 0); // cke was low: ignored
    step(1'b1, 1'b0, OP_ACT, 1'b0, 11'h3FF);     // previous cke low: ignored
    step(1'b1, 1'b1, OP_MRS, 1'b0, 0);           // deselect
    sec = "R6"; cmd(OP_ACT, 0, 11'h0AA);         // already open
    sec = "R7"; cmd(OP_RD, 1, 11'h010);          // bank B idle
    sec = "R6"; cmd(OP_ACT, 1, 11'h2AA);
    sec = "R8"; cmd(OP_WR, 0, 11'h012);          // plain burst
    idle(1);
    cmd(OP_RD, 1, 11'h434);                      // AP burst replaces plain one
    sec = "R9"; cmd(OP_RD, 0, 11'h001);          // blocked
    idle(1);
    cmd(OP_WR, 0, 11'h002);                      // last beat: still blocked
    cmd(OP_RD, 0, 11'h003);                      // burst over: legal
    idle(BL + 1);
    sec = "R7"; cmd(OP_RD, 1, 11'h005);          // bank B auto-closed
    sec = "R10"; cmd(OP_WR, 0, 11'h405);
    cmd(OP_BST, 0, 0);
    cmd(OP_RD, 0, 11'h006);                      // bank A closed by stop
    cmd(OP_BST, 0, 0);                           // no burst: no effect
    sec = "R11"; cmd(OP_ACT, 0, 11'h007);
    cmd(OP_ACT, 1, 11'h009);
    cmd(OP_RD, 1, 11'h020);
    cmd(OP_PRE, 1, 11'h000);                     // closes B, ends burst
    cmd(OP_RD, 1, 11'h021);
    cmd(OP_PRE, 0, 11'h400);                     // all banks
    sec = "R3"; cmd(OP_MRS, 1, 11'h7FF);
    sec = "R4"; step(1'b1, 1'b0, OP_NOP, 1'b0, 0);
    cmd(OP_BST, 0, 0);                           // second locked edge
    cmd(OP_REF, 0, 0);                           // lock over: legal refresh
    sec = "R12"; idle(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule